// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block is the bus-master side of a 16-bit processor core that talks to memory and peripherals over one shared set of address/data lines and a 20-bit address space. The core hands it a single request at a time: read or write, byte or word, a 20-bit address and, for writes, 16 bits of data. The controller then runs one or two external bus cycles. Each cycle puts the address on the shared lines together with a latch strobe, asserts a read or write strobe, stretches while the target holds READY low, and finishes with the strobe released.

The memory behind the bus is made of two 8-bit banks, low on lines 7..0 and high on lines 15..8. Address bit 0 and an active-low high-bank enable choose which banks take part. A word at an odd address cannot be moved in one cycle, so the controller breaks it into two byte cycles. On the core side, byte data is always right-justified, and a word is always in natural order.

Top module: `mbus_master`

## Requirements
- R1: After reset, and while no request is active: rd_n, wr_n and bhe_n are 1, ale is 0, ad_oe is 0, done is 0 and req_ready is 1.
- R2: Each external cycle starts with one T1 clock in which ale is 1, ad_oe is 1, ad_out carries address bits 15..0 and a_hi carries bits 19..16. ale is never high in two consecutive clocks.
- R3: The lanes are given by ad_out[0] in T1 and by bhe_n. An aligned word gives A0=0 with bhe_n=0. An even byte gives A0=0 with bhe_n=1. An odd byte gives A0=1 with bhe_n=0. At least one lane is enabled in every cycle.
- R4: A word at an odd address runs as two cycles. The first is at the address itself and uses the high lane with the low-order byte. The second is at address+1, modulo 2^20, and uses the low lane with the high-order byte.
- R5: The strobe goes low in T2 and stays low through T3. T3 repeats for as long as ready is sampled 0. With n wait states, one cycle lasts 4+n clocks and its strobe is low for 2+n clocks.
- R6: During a read, ad_oe is 0 whenever rd_n is 0, and rd_n and wr_n are never both low. The read data is taken at the clock edge that ends the last T3. A byte is returned in rdata[7:0] with the upper byte 0: it comes from ad_in[7:0] for an even address and from ad_in[15:8] for an odd one. A word is returned as {byte at addr+1, byte at addr}.
- R7: During a write, ad_oe is 1 from T1 through T4. Each enabled lane carries its write byte and a disabled lane carries 0.
- R8: req_ready is 1 only when idle, and a request is taken when req_valid and req_ready are both 1. done is a one-clock pulse during the T4 of the last cycle, and rdata is valid with it.
- R9: In T4, rd_n and wr_n are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data, byte right-justified |
| req_ready | output | 1 | Controller idle, request taken this clock |
| done | output | 1 | Completion pulse |
| rdata | output | 16 | Read result, byte right-justified |
| ad_out | output | 16 | Shared lines: address in T1, write data after |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 16 | Shared lines as sampled from the bus |
| a_hi | output | 4 | Address bits 19..16 |
| ale | output | 1 | Address latch strobe, T1 only |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High-bank enable, active low |
| ready | input | 1 | Target ready; 0 inserts wait states |

## Verification
The bench runs four kinds of access: aligned words, even bytes, odd bytes and odd-address words. Together they separate the three lane encodings from the two-cycle split and show whether each byte reaches the correct lane and the correct half of rdata. Each cycle gets a random count of 0 to 3 wait states. This shows whether READY is sampled only in T3 and whether the strobe and the cycle length grow by exactly that count. An odd-address word at FFFFFh checks that the second cycle wraps to 00000h. Read data is produced by a function of the address, so a data byte taken from the wrong lane or the wrong address gives a visible mismatch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // Bus cycle clock states
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  // Lane selection for one external cycle
  typedef struct packed {
    logic lo_en;      // low bank (lines 7..0) takes part
    logic hi_en;      // high bank (lines 15..8) takes part
    logic upper_src;  // single-byte cycle moves the core's high-order byte
  } lane_sel_t;

endpackage

// File: rtl/mbus_phase_plan.sv
module mbus_phase_plan
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_word,
  input  logic              phase,
  output logic [ADDR_W-1:0] ph_addr,
  output lane_sel_t         lanes,
  output logic              split
);

  // An odd-address word needs two byte cycles
  assign split   = op_word & op_addr[0];
  assign ph_addr = op_addr + {{(ADDR_W-1){1'b0}}, phase};

  always_comb begin
    if (op_word && !split) begin
      lanes.lo_en     = 1'b1;
      lanes.hi_en     = 1'b1;
      lanes.upper_src = 1'b0;
    end else begin
      lanes.lo_en     = ~ph_addr[0];
      lanes.hi_en     = ph_addr[0];
      lanes.upper_src = phase;
    end
  end

endmodule

// File: rtl/mbus_tstate_seq.sv
module mbus_tstate_seq
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ready,
  input  logic    split,
  output tstate_e state,
  output logic    phase,
  output logic    done,
  output logic    capture,
  output logic    strobe_on,
  output logic    busy
);

  tstate_e state_q, state_d;
  logic    phase_q, phase_d;

  // Next-state process
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    unique case (state_q)
      TS_IDLE: if (start) begin
        state_d = TS_T1;
        phase_d = 1'b0;
      end
      TS_T1: state_d = TS_T2;
      TS_T2: state_d = TS_T3;
      TS_T3: if (ready) state_d = TS_T4;
      TS_T4: if (split && !phase_q) begin
        state_d = TS_T1;
        phase_d = 1'b1;
      end else begin
        state_d = TS_IDLE;
      end
      default: state_d = TS_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign state     = state_q;
  assign phase     = phase_q;
  assign busy      = (state_q != TS_IDLE);
  assign strobe_on = (state_q == TS_T2) || (state_q == TS_T3);
  assign capture   = (state_q == TS_T3) && ready;
  assign done      = (state_q == TS_T4) && (!split || phase_q);

  // T3 repeats while the target is not ready
  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T3 && !ready) |=> (state_q == TS_T3));

  // T1 lasts exactly one clock
  assert_t1_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T1) |=> (state_q == TS_T2));

  // The first half of a split word is followed by a second cycle
  assert_split_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T4 && split && !phase_q) |=> (state_q == TS_T1 && phase_q));

endmodule

// File: rtl/mbus_lane_steer.sv
module mbus_lane_steer
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  lane_sel_t         lanes,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] wbus,
  output logic [DATA_W-1:0] rdata
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic              both;
  logic [BYTE_W-1:0] out_byte;
  logic [BYTE_W-1:0] in_byte;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign both     = lanes.lo_en & lanes.hi_en;
  assign out_byte = lanes.upper_src ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];
  assign in_byte  = lanes.hi_en ? ad_in[DATA_W-1:BYTE_W] : ad_in[BYTE_W-1:0];

  // Write steering, one slice per bank
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = (g == 0) ? lanes.lo_en : lanes.hi_en;
    always_comb begin
      if (!lane_en)  wbus[g*BYTE_W +: BYTE_W] = '0;
      else if (both) wbus[g*BYTE_W +: BYTE_W] = wdata[g*BYTE_W +: BYTE_W];
      else           wbus[g*BYTE_W +: BYTE_W] = out_byte;
    end
  end

  // Read merge: next-state
  always_comb begin
    rdata_d = rdata_q;
    if (clear) begin
      rdata_d = '0;
    end else if (capture) begin
      if (both)                 rdata_d = ad_in;
      else if (lanes.upper_src) rdata_d[DATA_W-1:BYTE_W] = in_byte;
      else                      rdata_d[BYTE_W-1:0] = in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // Every data capture has a bank selected
  assert_lane_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (lanes.lo_en || lanes.hi_en));

endmodule

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     bhe_n,
  input  logic                     ready
);

  localparam int HI_W = ADDR_W - DATA_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  tstate_e           state;
  logic              phase, busy, strobe_on, capture, split, accept;
  logic [ADDR_W-1:0] op_addr_q, ph_addr;
  logic [DATA_W-1:0] op_wdata_q, wbus;
  logic              op_word_q, op_write_q;
  lane_sel_t         lanes;

  assign accept = req_valid && !busy;

  // Request hold registers with explicit enable
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      op_word_q  <= 1'b0;
      op_write_q <= 1'b0;
    end else if (accept) begin
      op_addr_q  <= req_addr;
      op_wdata_q <= req_wdata;
      op_word_q  <= req_word;
      op_write_q <= req_write;
    end
  end

  mbus_phase_plan #(.ADDR_W(ADDR_W)) u_plan (
    .op_addr (op_addr_q),
    .op_word (op_word_q),
    .phase   (phase),
    .ph_addr (ph_addr),
    .lanes   (lanes),
    .split   (split)
  );

  mbus_tstate_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (accept),
    .ready     (ready),
    .split     (split),
    .state     (state),
    .phase     (phase),
    .done      (done),
    .capture   (capture),
    .strobe_on (strobe_on),
    .busy      (busy)
  );

  mbus_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clear   (accept),
    .capture (capture && !op_write_q),
    .lanes   (lanes),
    .wdata   (op_wdata_q),
    .ad_in   (ad_in),
    .wbus    (wbus),
    .rdata   (rdata)
  );

  // Pin drive
  assign req_ready = !busy;
  assign ale       = (state == TS_T1);
  assign ad_oe     = (state == TS_T1) || (busy && op_write_q);
  assign ad_out    = (state == TS_T1) ? ph_addr[DATA_W-1:0] :
                     (busy && op_write_q) ? wbus : '0;
  assign a_hi      = busy ? ph_addr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  assign bhe_n     = busy ? ~lanes.hi_en : 1'b1;
  assign rd_n      = ~(strobe_on && !op_write_q);
  assign wr_n      = ~(strobe_on && op_write_q);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(!rd_n && !wr_n));

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rd_n |-> !ad_oe);

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    ale |=> !ale);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);

  assert_t4_release_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state == TS_T4) |-> (rd_n && wr_n));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_ready |-> (!ale && rd_n && wr_n && bhe_n && !ad_oe && !done));

endmodule

// File: tb/tb_mbus_master.sv
module tb_mbus_master;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, done;
  logic [15:0] rdata, ad_out, ad_in;
  logic        ad_oe, ale, rd_n, wr_n, bhe_n, ready;
  logic [3:0]  a_hi;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  mbus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .bhe_n(bhe_n), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Target memory contents as a function of the address
  function automatic logic [7:0] memb(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] exp_read(input logic wd, input logic [19:0] a);
    if (wd) return {memb(a + 20'd1), memb(a)};
    return {8'h00, memb(a)};
  endfunction

  task automatic run_op(input logic wr, input logic wd, input logic [19:0] ad,
                        input logic [15:0] wv);
    int k = 0, ph = -1, idx = 0, n = 0, exp_len = 0, strb = 0, ncap = 0;
    bit finished = 0;
    bit split;
    logic [19:0] cur = '0, e;
    logic [19:0] cap_a [4];
    logic [7:0]  cap_b [4];
    logic [7:0]  eb;
    split = wd & ad[0];
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = ad; req_wdata = wv;
    @(negedge clk);
    req_valid = 1'b0;
    while (!finished) begin
      k++;
      check(req_ready == 1'b0, "R8 busy", {31'd0, req_ready}, 0);
      if (ale) begin
        ph++;
        idx = 0;
        n = $urandom_range(0, 3);
        exp_len += 4 + n;
        strb = 0;
        e = ad + ph[19:0];
        cur = {a_hi, ad_out};
        check(cur == e, "R2/R4 cycle address", {12'd0, cur}, {12'd0, e});
        check(ad_oe == 1'b1, "R2 address driven", {31'd0, ad_oe}, 1);
        check(rd_n && wr_n, "R2 no strobe in T1", {30'd0, rd_n, wr_n}, 3);
        check(ad_out[0] == e[0], "R3 A0", {31'd0, ad_out[0]}, {31'd0, e[0]});
        check(bhe_n == !((wd && !split) || e[0]), "R3 high enable",
              {31'd0, bhe_n}, {31'd0, !((wd && !split) || e[0])});
        ad_in = {memb({e[19:1], 1'b1}), memb({e[19:1], 1'b0})};
      end else begin
        idx++;
      end
      if (!rd_n || !wr_n) strb++;
      if (!rd_n) check(ad_oe == 1'b0, "R6 bus released on read", {31'd0, ad_oe}, 0);
      if (!wr_n) check(ad_oe == 1'b1, "R7 bus driven on write", {31'd0, ad_oe}, 1);
      ready = !(idx >= 2 && idx - 2 < n);
      if (!wr_n && idx >= 2 && ready) begin
        if (!bhe_n) begin cap_a[ncap] = {cur[19:1], 1'b1}; cap_b[ncap] = ad_out[15:8]; ncap++; end
        else check(ad_out[15:8] == 8'h00, "R7 idle high lane", {24'd0, ad_out[15:8]}, 0);
        if (!cur[0]) begin cap_a[ncap] = {cur[19:1], 1'b0}; cap_b[ncap] = ad_out[7:0]; ncap++; end
        else check(ad_out[7:0] == 8'h00, "R7 idle low lane", {24'd0, ad_out[7:0]}, 0);
      end
      if (idx == 3 + n) begin
        check(rd_n && wr_n, "R9 strobe released in T4", {30'd0, rd_n, wr_n}, 3);
        check(strb == 2 + n, "R5 strobe length", strb, 2 + n);
        if (wr) check(ad_oe == 1'b1, "R7 data held in T4", {31'd0, ad_oe}, 1);
      end
      if (done) begin
        finished = 1;
        check(k == exp_len, "R5/R8 done timing", k, exp_len);
        check(ph == (split ? 1 : 0), "R4 cycle count", ph, split ? 1 : 0);
        if (!wr) check(rdata == exp_read(wd, ad), "R6 read data", {16'd0, rdata},
                       {16'd0, exp_read(wd, ad)});
        else begin
          check(ncap == (wd ? 2 : 1), "R7 bytes written", ncap, wd ? 2 : 1);
          for (int i = 0; i < ncap && i < 4; i++) begin
            if (cap_a[i] == ad) eb = wv[7:0];
            else if (wd && cap_a[i] == ad + 20'd1) eb = wv[15:8];
            else eb = ~cap_b[i];
            check(cap_b[i] == eb, "R7/R4 write byte", {12'd0, cap_a[i]}, {24'd0, eb});
          end
        end
      end
      if (k > 60) begin
        check(0, "R8 op watchdog", k, exp_len);
        finished = 1;
      end
      if (!finished) @(negedge clk);
    end
    ready = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R8 done one clock", {31'd0, done}, 0);
    check(req_ready == 1'b1, "R1 idle after op", {31'd0, req_ready}, 1);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; ad_in = '0; ready = 1'b1;
    repeat (3) @(negedge clk);
    check(rd_n && wr_n && bhe_n && !ale && !ad_oe && !done && req_ready,
          "R1 reset state", {25'd0, rd_n, wr_n, bhe_n, ale, ad_oe, done, req_ready}, 7'h71);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_n && wr_n && bhe_n && !ale && !ad_oe && !done && req_ready,
          "R1 idle after reset", {25'd0, rd_n, wr_n, bhe_n, ale, ad_oe, done, req_ready}, 7'h71);
    // Directed corners
    run_op(1'b0, 1'b1, 20'h12344, 16'h0000);  // aligned word read
    run_op(1'b1, 1'b1, 20'hA0010, 16'hBEEF);  // aligned word write
    run_op(1'b0, 1'b0, 20'h00102, 16'h0000);  // even byte read
    run_op(1'b0, 1'b0, 20'h00103, 16'h0000);  // odd byte read
    run_op(1'b1, 1'b0, 20'h55555, 16'h00C3);  // odd byte write
    run_op(1'b1, 1'b0, 20'h55554, 16'h003C);  // even byte write
    run_op(1'b0, 1'b1, 20'h0FFFF, 16'h0000);  // split word read across 64K
    run_op(1'b1, 1'b1, 20'h3ABC7, 16'h1234);  // split word write
    run_op(1'b0, 1'b1, 20'hFFFFF, 16'h0000);  // split word wrapping to 0
    run_op(1'b1, 1'b1, 20'hFFFFF, 16'h9A7E);
    // Random mix
    for (int i = 0; i < 80; i++) begin
      run_op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
             20'($urandom), 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule